// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Open-Drain

This block is a register-mapped I/O port of up to 16 pins. Software reaches it through a small bus with a two-bit register address, a write strobe, write data and read data that is valid in the same cycle. Four registers set up the port: the direction register, the pin-level register, the output latch and the open-drain select. The pin-level and latch registers differ only when read. Writing either one loads the same output latch. Reading the pin-level register returns the synchronized pad inputs, and reading the latch returns what was last written. Software can therefore do read-modify-write on the latch without copying slow-moving pad levels back into it.

Any pin can be handed to a peripheral. A per-pin select replaces the latch value and the direction-derived enable with the peripheral's own value and enable. The open-drain transform comes after this selection, so peripheral-owned pins can also run open-drain. Two parameter masks mark pins that do not exist and pins that are dedicated I2C lines. The I2C lines are open-drain in the pad, so their open-drain bit has no effect here.

Top module: `gpio_port`

## Requirements
- R1: A write to address 1 (pin-level) or address 2 (latch) loads the output latch on that clock edge. A read of address 2 returns the latch contents in the same cycle.
- R2: A read of address 1 returns the pad input levels through a two-stage synchronizer. A pad change made between edges is visible after the second following rising edge and not after the first.
- R3: Direction register at address 0: bit value 1 makes the pin an input (output enable 0), and 0 makes it an output. A push-pull output drives the latch (or peripheral) value.
- R4: After reset, the direction bits of implemented pins read 1, and the latch and the open-drain register (address 3) read 0.
- R5: A pin whose open-drain bit is 1 never drives high. Its pad output is 0, and its output enable is asserted only when the selected value is 0 and the pin is an output.
- R6: When a pin's peripheral select is 1, the peripheral's value and enable replace the latch and direction for that pin, and the open-drain transform still applies.
- R7: Pins marked in the I2C mask ignore their open-drain bit and behave as push-pull at this boundary.
- R8: Pins outside the implemented mask read 0 in all four registers, ignore writes, and never assert pad output or output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 pin level, 2 latch, 3 open-drain |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the selected register |
| periph_sel | input | WIDTH | Per-pin peripheral ownership |
| periph_out | input | WIDTH | Peripheral output value |
| periph_oe | input | WIDTH | Peripheral output enable |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |

## Verification
A corrupted latch or open-drain bit appears on pad_out or pad_oe in the same cycle the register changes. It also shows on a latch read one edge after the write. A wrong synchronizer depth appears as a pin-level read that changes one edge early or late. The bench therefore samples those reads after exactly one and exactly two edges. A bit of an unimplemented pin that gets stored shows at once as a nonzero bit on a register read. An open-drain pin that drives high shows on the pad outputs in the cycle its configuration is applied.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] IMPL_MASK = {WIDTH{1'b1}},
  parameter logic [WIDTH-1:0] I2C_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] periph_sel,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  localparam logic [1:0] A_DIR = 2'd0, A_PIN = 2'd1, A_LAT = 2'd2, A_ODC = 2'd3;

  logic [WIDTH-1:0] dir_q, lat_q, odc_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] wmask, src_val, src_oe, od_en;

  assign wmask = bus_wdata & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= IMPL_MASK;
      lat_q <= '0;
      odc_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DIR:        dir_q <= wmask;
        A_PIN, A_LAT: lat_q <= wmask;
        default:      odc_q <= wmask;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    sync1_q <= pad_in;
    sync2_q <= sync1_q;
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_PIN:   bus_rdata = sync2_q & IMPL_MASK;
      A_LAT:   bus_rdata = lat_q;
      default: bus_rdata = odc_q;
    endcase
  end

  assign src_val = (periph_sel & periph_out) | (~periph_sel & lat_q);
  assign src_oe  = (periph_sel & periph_oe)  | (~periph_sel & ~dir_q);
  assign od_en   = odc_q & ~I2C_MASK;

  assign pad_out = src_val & ~od_en & IMPL_MASK;
  assign pad_oe  = src_oe & ~(od_en & src_val) & IMPL_MASK;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] IMPL_MASK = {WIDTH{1'b1}},
  parameter logic [WIDTH-1:0] I2C_MASK = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] periph_sel,
  input logic [WIDTH-1:0] periph_out,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] odc_q,
  input logic [WIDTH-1:0] lat_q
);
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> lat_q == ($past(bus_wdata) & IMPL_MASK)); // R1
  AST_PIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> bus_rdata == ($past(pad_in, 2) & IMPL_MASK)); // R2
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_out & odc_q & ~I2C_MASK) == '0)); // R5
  AST_PERIPH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ periph_out) & periph_sel & ~(odc_q & ~I2C_MASK) & IMPL_MASK) == '0)); // R6
  AST_UNIMPL_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out | pad_oe) & ~IMPL_MASK) == '0)); // R8
  AST_UNIMPL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~IMPL_MASK) == '0)); // R8
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK), .I2C_MASK(I2C_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .periph_sel(periph_sel), .periph_out(periph_out), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .odc_q(odc_q), .lat_q(lat_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] IMPL = 16'h7FFF;
  localparam logic [W-1:0] I2C  = 16'h0003;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, periph_sel = 0, periph_out = 0, periph_oe = 0, pad_in = 0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.WIDTH(W), .IMPL_MASK(IMPL), .I2C_MASK(I2C)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .periph_sel(periph_sel), .periph_out(periph_out),
    .periph_oe(periph_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  // dir, lat, odc, psel, pout, poe, exp_out, exp_oe
  localparam int NV = 5;
  localparam logic [8*W-1:0] VEC [NV] = '{
    {16'h0000, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h00FF, 16'h7FFF}, // R3
    {16'h0000, 16'h00FF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0003, 16'h7F03}, // R5 R7
    {16'hFFFF, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h00FF, 16'h0000}, // R3
    {16'hFFFF, 16'h0000, 16'h00F0, 16'h00FF, 16'h00AA, 16'h000F, 16'h000A, 16'h000F}, // R6
    {16'hFFFF, 16'h0000, 16'h00F0, 16'h00F0, 16'h0050, 16'h00F0, 16'h0000, 16'h00A0}  // R6 R5
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [W-1:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(0, "R4 dir reset", 16'h7FFF);
        rd(2, "R4 latch reset", 16'h0000);
        rd(3, "R4 odc reset", 16'h0000);
        chk("R4 pad_oe reset", pad_oe, 16'h0000);

        for (int i = 0; i < NV; i++) begin
          wr(0, VEC[i][8*W-1 -: W]);
          wr(2, VEC[i][7*W-1 -: W]);
          wr(3, VEC[i][6*W-1 -: W]);
          periph_sel = VEC[i][5*W-1 -: W];
          periph_out = VEC[i][4*W-1 -: W];
          periph_oe  = VEC[i][3*W-1 -: W];
          #1;
          chk($sformatf("R3/R5/R6/R7 vec%0d pad_out", i), pad_out, VEC[i][2*W-1 -: W]);
          chk($sformatf("R3/R5/R6/R7 vec%0d pad_oe", i), pad_oe, VEC[i][W-1 -: W]);
        end
        periph_sel = 0; periph_out = 0; periph_oe = 0;

        wr(1, 16'h1234);
        rd(2, "R1 latch via pin address", 16'h1234);
        wr(2, 16'hFFFF);
        rd(2, "R8 latch unimpl bit", 16'h7FFF);
        wr(0, 16'hFFFF);
        rd(0, "R8 dir unimpl bit", 16'h7FFF);
        wr(3, 16'h8000);
        rd(3, "R8 odc unimpl bit", 16'h0000);

        @(negedge clk);
        pad_in = 16'h0000;
        repeat (3) @(negedge clk);
        pad_in = 16'hC3A5;
        @(negedge clk);
        rd(1, "R2 one edge old", 16'h0000);
        @(negedge clk);
        rd(1, "R2 two edges new", 16'h43A5);
        rd(2, "R2 latch unaffected by pads", 16'h7FFF);

        wr(0, 16'h0000);
        wr(2, 16'h0000);
        wr(3, 16'h0000);
        #1;
        chk("R3 push-pull low drives", pad_oe, 16'h7FFF);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule